// File: doc/BRIEF.md
# Packed-Instruction Sequencing Controller

This block is the control sequencer of a small 16-bit processor core. It steps through a fixed cycle of fetch, one memory wait, instruction-register load and decode, and it drives the strobes that steer the datapath: program-counter clear, step and load, instruction-register load, register-file write and operand selects, window-pointer clear and step, the ALU operation code, flag load and flag clear, and memory read and write. The datapath and the memory sit outside. The block reads back only the instruction register contents and the zero and carry flags.

A fetched 16-bit word holds either one long instruction or two short ones. A long instruction uses its low byte as an immediate. Two packed short instructions run upper byte first, then lower byte, with no second fetch. If the lower byte is all zeros it is skipped. The program counter then advances once for the whole word. A halt opcode in either byte parks the sequencer with every strobe inactive until reset is applied again.

Top module: `shadow_ctrl`

## Requirements
- R1: While `rst_n` is low, and in the first cycle after it rises, exactly `pc_clr`, `wp_clr` and `flags_clr` are high and every other output is 0.
- R2: A fetch holds `mem_rd` high for three consecutive cycles (address, one wait, latch). `ir_load` is high only in the third of them, and `mem_wr` and `addr_from_reg` stay low throughout.
- R3: A short upper byte is decoded one cycle after the latch cycle and runs the cycle after that. The lower byte is then decoded and, if run, runs one cycle later. Each half's opcode is its top four bits (word bits 15:12 and 7:4).
- R4: `pc_inc` pulses for exactly one cycle once per word that is not a taken jump, one cycle after the last executing or skip-decoding cycle. A new fetch follows immediately.
- R5: A lower byte equal to 0x00 gets no execute cycle: its decode cycle is followed directly by the `pc_inc` cycle.
- R6: Strobes for a short opcode in its execute cycle. 1 (move) writes the register file with `alu_op`=1 and no flag load. 2 to 8 and 10 write the register file, load the flags and set `alu_op` to the opcode. 9 (compare) loads the flags only, with `alu_op`=9. 11 steps the window pointer, 12 clears the flags, and 13 stores (`mem_wr` with `addr_from_reg`). 0, and 15 in the lower byte, assert nothing.
- R7: Upper opcode 15 is a long instruction and executes for one cycle. Its right field (bits 9:8) selects the action: 0 loads the immediate (`rf_wr` and `rf_imm_sel`), 1 jumps unconditionally (`pc_load`), 2 jumps on zero and 3 jumps on carry.
- R8: A taken jump asserts `pc_load` and is followed at once by a fetch with no `pc_inc`. An untaken conditional jump asserts no `pc_load` and is followed by the `pc_inc` cycle.
- R9: Opcode 14 in the upper byte, or as the lower byte's opcode, enters a halt state that holds every output at 0 until the next reset.
- R10: In execute cycles `rf_left`/`rf_right` carry the active instruction's left and right fields (bits 11:10/9:8 for the upper byte and long form, 3:2/1:0 for the lower byte). In all other cycles both are 0.
- R11: At most one of `pc_clr`, `pc_inc` and `pc_load` is high in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| ir_q | input | 16 | Current instruction register contents |
| flag_z | input | 1 | Zero flag from the status register |
| flag_c | input | 1 | Carry flag from the status register |
| mem_rd | output | 1 | Memory read request |
| mem_wr | output | 1 | Memory write request |
| addr_from_reg | output | 1 | Memory address comes from a register instead of the PC |
| ir_load | output | 1 | Instruction register captures the data bus |
| pc_clr | output | 1 | Clear program counter |
| pc_inc | output | 1 | Advance program counter by one |
| pc_load | output | 1 | Load program counter from the immediate |
| rf_wr | output | 1 | Register file write enable |
| rf_imm_sel | output | 1 | Register write data is the immediate |
| rf_left | output | 2 | Left (destination) register select |
| rf_right | output | 2 | Right (source) register select |
| wp_clr | output | 1 | Clear window pointer |
| wp_add | output | 1 | Step window pointer |
| alu_op | output | 4 | ALU operation code (0 = none) |
| flags_ld | output | 1 | Load zero and carry flags |
| flags_clr | output | 1 | Clear flags |

## Verification
Every strobe is decoded from the state register and the instruction register in the same cycle, so a result is due in the cycle its state is entered. A new instruction word is due one cycle after the latch cycle, once the bench's own model of the instruction register has captured it on that edge. Jump decisions follow the flags in the long-execute cycle, and the fetch or `pc_inc` that comes next lands one edge later. The bench steps a behavioural phase model on each rising edge. On each falling edge it compares the full output vector against the vector computed from that phase, so each check sits in the exact cycle where the result is due.

// File: rtl/shadow_ctrl_pkg.sv
// Package: shared encodings for the packed-instruction sequencer.
// Assumes an instruction byte is opcode | left select | right select.
package shadow_ctrl_pkg;

    localparam int OPC_W = 4;
    localparam int SEL_W = 2;
    localparam int ALU_W = 4;

    // Short opcodes (opcode field of either byte)
    localparam logic [OPC_W-1:0] OP_NOP   = 4'd0;
    localparam logic [OPC_W-1:0] OP_MOV   = 4'd1;
    localparam logic [OPC_W-1:0] OP_ADD   = 4'd2;
    localparam logic [OPC_W-1:0] OP_SUB   = 4'd3;
    localparam logic [OPC_W-1:0] OP_AND   = 4'd4;
    localparam logic [OPC_W-1:0] OP_OR    = 4'd5;
    localparam logic [OPC_W-1:0] OP_NOT   = 4'd6;
    localparam logic [OPC_W-1:0] OP_SHL   = 4'd7;
    localparam logic [OPC_W-1:0] OP_SHR   = 4'd8;
    localparam logic [OPC_W-1:0] OP_CMP   = 4'd9;
    localparam logic [OPC_W-1:0] OP_MUL   = 4'd10;
    localparam logic [OPC_W-1:0] OP_WPADD = 4'd11;
    localparam logic [OPC_W-1:0] OP_FCLR  = 4'd12;
    localparam logic [OPC_W-1:0] OP_STORE = 4'd13;
    localparam logic [OPC_W-1:0] OP_HALT  = 4'd14;
    localparam logic [OPC_W-1:0] OP_LONG  = 4'd15;

    // Long-form actions (right field of a long instruction)
    localparam logic [SEL_W-1:0] LF_LDI = 2'd0;
    localparam logic [SEL_W-1:0] LF_JMP = 2'd1;
    localparam logic [SEL_W-1:0] LF_JZ  = 2'd2;
    localparam logic [SEL_W-1:0] LF_JC  = 2'd3;

    typedef enum logic [3:0] {
        ST_RESET,
        ST_FETCH,
        ST_MWAIT,
        ST_LATCH,
        ST_DEC_HI,
        ST_EXEC_LONG,
        ST_EXEC_HI,
        ST_DEC_LO,
        ST_EXEC_LO,
        ST_PC_ADV,
        ST_HALT
    } ctl_state_e;

    typedef enum logic [1:0] {
        HK_ZERO,
        HK_SHORT,
        HK_LONG,
        HK_HALT
    } half_kind_e;

    typedef struct packed {
        logic             mem_rd;
        logic             mem_wr;
        logic             addr_from_reg;
        logic             ir_load;
        logic             pc_clr;
        logic             pc_inc;
        logic             pc_load;
        logic             rf_wr;
        logic             rf_imm_sel;
        logic [SEL_W-1:0] rf_left;
        logic [SEL_W-1:0] rf_right;
        logic             wp_clr;
        logic             wp_add;
        logic [ALU_W-1:0] alu_op;
        logic             flags_ld;
        logic             flags_clr;
    } ctl_bus_t;

endpackage

// File: rtl/shadow_ctrl_bytedec.sv
// Module: decodes one instruction byte into its kind and its execute strobes.
// Assumes HALF_W = OPC_W + 2*SEL_W; the strobes are used only in an execute state.
module shadow_ctrl_bytedec
    import shadow_ctrl_pkg::*;
#(
    parameter int HALF_W = 8
) (
    input  logic [HALF_W-1:0] half_i,
    output half_kind_e        kind_o,
    output ctl_bus_t          ctl_o
);

    localparam int OPC_LSB  = HALF_W - OPC_W;
    localparam int LEFT_LSB = SEL_W;

    logic [OPC_W-1:0] opc;
    assign opc = half_i[OPC_LSB +: OPC_W];

    // Purpose: classify the byte for the sequencer.
    always_comb begin
        if (half_i == '0)        kind_o = HK_ZERO;
        else if (opc == OP_HALT) kind_o = HK_HALT;
        else if (opc == OP_LONG) kind_o = HK_LONG;
        else                     kind_o = HK_SHORT;
    end

    // Purpose: build the execute-cycle strobes for a short opcode.
    always_comb begin
        ctl_o          = '0;
        ctl_o.rf_left  = half_i[LEFT_LSB +: SEL_W];
        ctl_o.rf_right = half_i[0 +: SEL_W];
        unique case (opc)
            OP_MOV: begin
                ctl_o.rf_wr  = 1'b1;
                ctl_o.alu_op = opc;
            end
            OP_ADD, OP_SUB, OP_AND, OP_OR, OP_NOT, OP_SHL, OP_SHR, OP_MUL: begin
                ctl_o.rf_wr    = 1'b1;
                ctl_o.alu_op   = opc;
                ctl_o.flags_ld = 1'b1;
            end
            OP_CMP: begin
                ctl_o.alu_op   = opc;
                ctl_o.flags_ld = 1'b1;
            end
            OP_WPADD: ctl_o.wp_add    = 1'b1;
            OP_FCLR:  ctl_o.flags_clr = 1'b1;
            OP_STORE: begin
                ctl_o.mem_wr        = 1'b1;
                ctl_o.addr_from_reg = 1'b1;
            end
            default: ;
        endcase
    end

endmodule

// File: rtl/shadow_ctrl_longdec.sv
// Module: decodes the long form from its select fields and the flags.
// Assumes the immediate is routed by the datapath; only the action is decided here.
module shadow_ctrl_longdec
    import shadow_ctrl_pkg::*;
(
    input  logic [2*SEL_W-1:0] sel_i,
    input  logic               flag_z_i,
    input  logic               flag_c_i,
    output ctl_bus_t           ctl_o,
    output logic               taken_o
);

    logic [SEL_W-1:0] action;
    assign action = sel_i[0 +: SEL_W];

    // Purpose: decide whether the long instruction redirects the PC.
    always_comb begin
        unique case (action)
            LF_JMP:  taken_o = 1'b1;
            LF_JZ:   taken_o = flag_z_i;
            LF_JC:   taken_o = flag_c_i;
            default: taken_o = 1'b0;
        endcase
    end

    // Purpose: build the long-execute strobes.
    always_comb begin
        ctl_o            = '0;
        ctl_o.rf_left    = sel_i[SEL_W +: SEL_W];
        ctl_o.rf_right   = action;
        ctl_o.rf_wr      = (action == LF_LDI);
        ctl_o.rf_imm_sel = (action == LF_LDI);
        ctl_o.pc_load    = taken_o;
    end

endmodule

// File: rtl/shadow_ctrl_seq.sv
// Module: eleven-state sequencer with one memory wait and a shadow slot.
// Assumes the instruction register is valid from the upper-decode state on.
module shadow_ctrl_seq
    import shadow_ctrl_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  half_kind_e hi_kind_i,
    input  half_kind_e lo_kind_i,
    input  logic       jump_taken_i,
    output ctl_state_e state_o
);

    ctl_state_e state_q, state_d;

    // Purpose: state register with synchronous active-low reset.
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_RESET;
        else        state_q <= state_d;
    end

    // Purpose: next-state selection.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_RESET:  state_d = ST_FETCH;
            ST_FETCH:  state_d = ST_MWAIT;
            ST_MWAIT:  state_d = ST_LATCH;
            ST_LATCH:  state_d = ST_DEC_HI;
            ST_DEC_HI: begin
                unique case (hi_kind_i)
                    HK_HALT: state_d = ST_HALT;
                    HK_LONG: state_d = ST_EXEC_LONG;
                    default: state_d = ST_EXEC_HI;
                endcase
            end
            ST_EXEC_LONG: state_d = jump_taken_i ? ST_FETCH : ST_PC_ADV;
            ST_EXEC_HI:   state_d = ST_DEC_LO;
            ST_DEC_LO: begin
                unique case (lo_kind_i)
                    HK_ZERO: state_d = ST_PC_ADV;
                    HK_HALT: state_d = ST_HALT;
                    default: state_d = ST_EXEC_LO;
                endcase
            end
            ST_EXEC_LO: state_d = ST_PC_ADV;
            ST_PC_ADV:  state_d = ST_FETCH;
            ST_HALT:    state_d = ST_HALT;
            default:    state_d = ST_RESET;
        endcase
    end

    assign state_o = state_q;

    // R9: halt is left only through reset
    assert_halt_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_HALT) |=> (state_q == ST_HALT));

    // R5: an all-zero lower byte goes straight to the PC step
    assert_shadow_skip_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_DEC_LO && lo_kind_i == HK_ZERO) |=> (state_q == ST_PC_ADV));

    // R7: a long upper byte gets the long execute cycle
    assert_long_path_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_DEC_HI && hi_kind_i == HK_LONG) |=> (state_q == ST_EXEC_LONG));

endmodule

// File: rtl/shadow_ctrl.sv
// Module: top of the packed-instruction controller; decodes strobes per state.
// Assumes the datapath latches the bus into ir_q on an ir_load cycle.
module shadow_ctrl
    import shadow_ctrl_pkg::*;
#(
    parameter int WORD_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WORD_W-1:0] ir_q,
    input  logic             flag_z,
    input  logic             flag_c,
    output logic             mem_rd,
    output logic             mem_wr,
    output logic             addr_from_reg,
    output logic             ir_load,
    output logic             pc_clr,
    output logic             pc_inc,
    output logic             pc_load,
    output logic             rf_wr,
    output logic             rf_imm_sel,
    output logic [1:0]       rf_left,
    output logic [1:0]       rf_right,
    output logic             wp_clr,
    output logic             wp_add,
    output logic [3:0]       alu_op,
    output logic             flags_ld,
    output logic             flags_clr
);

    localparam int HALF_W = WORD_W / 2;
    localparam int N_HALF = 2;
    localparam int HI     = 1;
    localparam int LO     = 0;

    half_kind_e kind   [N_HALF];
    ctl_bus_t   half_ctl [N_HALF];
    ctl_bus_t   long_ctl;
    ctl_bus_t   ctl;
    logic       jump_taken;
    ctl_state_e state;

    // One decoder per byte of the word
    for (genvar g = 0; g < N_HALF; g++) begin : g_half
        shadow_ctrl_bytedec #(.HALF_W(HALF_W)) u_dec (
            .half_i (ir_q[g*HALF_W +: HALF_W]),
            .kind_o (kind[g]),
            .ctl_o  (half_ctl[g])
        );
    end

    shadow_ctrl_longdec u_long (
        .sel_i    (ir_q[HALF_W +: 2*SEL_W]),
        .flag_z_i (flag_z),
        .flag_c_i (flag_c),
        .ctl_o    (long_ctl),
        .taken_o  (jump_taken)
    );

    shadow_ctrl_seq u_seq (
        .clk          (clk),
        .rst_n        (rst_n),
        .hi_kind_i    (kind[HI]),
        .lo_kind_i    (kind[LO]),
        .jump_taken_i (jump_taken),
        .state_o      (state)
    );

    // Purpose: pick the strobe set that belongs to the current state.
    always_comb begin
        ctl = '0;
        unique case (state)
            ST_RESET: begin
                ctl.pc_clr    = 1'b1;
                ctl.wp_clr    = 1'b1;
                ctl.flags_clr = 1'b1;
            end
            ST_FETCH, ST_MWAIT: ctl.mem_rd = 1'b1;
            ST_LATCH: begin
                ctl.mem_rd  = 1'b1;
                ctl.ir_load = 1'b1;
            end
            ST_EXEC_LONG: ctl = long_ctl;
            ST_EXEC_HI:   ctl = half_ctl[HI];
            ST_EXEC_LO:   ctl = half_ctl[LO];
            ST_PC_ADV:    ctl.pc_inc = 1'b1;
            default: ;
        endcase
    end

    assign mem_rd        = ctl.mem_rd;
    assign mem_wr        = ctl.mem_wr;
    assign addr_from_reg = ctl.addr_from_reg;
    assign ir_load       = ctl.ir_load;
    assign pc_clr        = ctl.pc_clr;
    assign pc_inc        = ctl.pc_inc;
    assign pc_load       = ctl.pc_load;
    assign rf_wr         = ctl.rf_wr;
    assign rf_imm_sel    = ctl.rf_imm_sel;
    assign rf_left       = ctl.rf_left;
    assign rf_right      = ctl.rf_right;
    assign wp_clr        = ctl.wp_clr;
    assign wp_add        = ctl.wp_add;
    assign alu_op        = ctl.alu_op;
    assign flags_ld      = ctl.flags_ld;
    assign flags_clr     = ctl.flags_clr;

    // R2: the latch cycle follows two read cycles (one wait state)
    assert_wait_state_R2: assert property (@(posedge clk) disable iff (!rst_n)
        ir_load |-> ($past(mem_rd) && $past(mem_rd, 2) && !$past(ir_load)));

    // R11: never two PC actions at once
    assert_pc_single_R11: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({pc_clr, pc_inc, pc_load}));

    // R4: a PC step is followed by a fresh fetch
    assert_fetch_after_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
        pc_inc |=> (mem_rd && !ir_load && !pc_inc));

    // R9: halt keeps every strobe inactive
    assert_halt_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_HALT) |-> (ctl == '0));

    // R10: register selects idle outside execute states
    assert_fields_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !(state inside {ST_EXEC_LONG, ST_EXEC_HI, ST_EXEC_LO}) |-> (rf_left == '0 && rf_right == '0));

endmodule

// File: tb/shadow_ctrl_bench.sv
`timescale 1ns/1ps
module shadow_ctrl_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] ir_q = '0;
    logic        flag_z = 1'b0;
    logic        flag_c = 1'b0;
    logic        mem_rd, mem_wr, addr_from_reg, ir_load, pc_clr, pc_inc, pc_load;
    logic        rf_wr, rf_imm_sel, wp_clr, wp_add, flags_ld, flags_clr;
    logic [1:0]  rf_left, rf_right;
    logic [3:0]  alu_op;

    int n_tests = 0;
    int n_fail  = 0;
    bit armed   = 1'b0;
    bit done    = 1'b0;

    logic [15:0] mem [64];
    int          ph = 0;      // model phase: 0 reset,1 fetch,2 wait,3 latch,4 dec hi,5 long,6 exec hi,7 dec lo,8 exec lo,9 pc step,10 halt
    logic [7:0]  pc = '0;

    always #2.5 clk = ~clk;

    shadow_ctrl u_shadow_ctrl (
        .clk(clk), .rst_n(rst_n), .ir_q(ir_q), .flag_z(flag_z), .flag_c(flag_c),
        .mem_rd(mem_rd), .mem_wr(mem_wr), .addr_from_reg(addr_from_reg), .ir_load(ir_load),
        .pc_clr(pc_clr), .pc_inc(pc_inc), .pc_load(pc_load), .rf_wr(rf_wr),
        .rf_imm_sel(rf_imm_sel), .rf_left(rf_left), .rf_right(rf_right),
        .wp_clr(wp_clr), .wp_add(wp_add), .alu_op(alu_op), .flags_ld(flags_ld),
        .flags_clr(flags_clr)
    );

    function automatic bit jump_taken(input logic [15:0] w, input logic z, input logic c);
        return (w[9:8] == 2'd1) || (w[9:8] == 2'd2 && z) || (w[9:8] == 2'd3 && c);
    endfunction

    // Vector bits: 20 rd,19 wr,18 afr,17 irld,16 pcclr,15 pcinc,14 pcld,13 rfwr,12 imm,
    // 11:10 left,9:8 right,7 wpclr,6 wpadd,5:2 alu,1 fld,0 fclr
    function automatic logic [20:0] short_vec(input logic [7:0] b);
        logic [20:0] v = '0;
        logic [3:0]  opc = b[7:4];
        v[11:10] = b[3:2];
        v[9:8]   = b[1:0];
        if (opc inside {[4'd1:4'd8], 4'd10}) begin
            v[13] = 1'b1; v[5:2] = opc; v[1] = (opc != 4'd1);
        end else if (opc == 4'd9) begin
            v[5:2] = opc; v[1] = 1'b1;
        end else if (opc == 4'd11) v[6] = 1'b1;
        else if (opc == 4'd12) v[0] = 1'b1;
        else if (opc == 4'd13) begin v[19] = 1'b1; v[18] = 1'b1; end
        return v;
    endfunction

    function automatic logic [20:0] expect_vec(input int p, input logic [15:0] w, input logic z, input logic c);
        logic [20:0] v = '0;
        case (p)
            0: begin v[16] = 1'b1; v[7] = 1'b1; v[0] = 1'b1; end
            1, 2: v[20] = 1'b1;
            3: begin v[20] = 1'b1; v[17] = 1'b1; end
            5: begin
                v[11:10] = w[11:10]; v[9:8] = w[9:8];
                if (w[9:8] == 2'd0) begin v[13] = 1'b1; v[12] = 1'b1; end
                if (jump_taken(w, z, c)) v[14] = 1'b1;
            end
            6: v = short_vec(w[15:8]);
            8: v = short_vec(w[7:0]);
            9: v[15] = 1'b1;
            default: ;
        endcase
        return v;
    endfunction

    function automatic string tag_of(input int p, input logic [15:0] w);
        case (p)
            0: return "R1";
            1, 2, 3: return "R2";
            4: return "R3";
            5: return (w[9:8] >= 2'd1) ? "R8" : "R7";
            6, 8: return "R6/R10";
            7: return "R5";
            9: return "R4";
            default: return "R9";
        endcase
    endfunction

    // Reference model: phase, PC and instruction register advance on each rising edge
    always @(posedge clk) begin
        armed <= 1'b1;
        if (!rst_n) begin
            ph <= 0; pc <= '0;
        end else begin
            case (ph)
                0: begin ph <= 1; pc <= '0; end
                1: ph <= 2;
                2: ph <= 3;
                3: begin ph <= 4; ir_q <= mem[pc[5:0]]; end
                4: ph <= (ir_q[15:12] == 4'd14) ? 10 : (ir_q[15:12] == 4'd15) ? 5 : 6;
                5: if (jump_taken(ir_q, flag_z, flag_c)) begin pc <= ir_q[7:0]; ph <= 1; end
                   else ph <= 9;
                6: ph <= 7;
                7: ph <= (ir_q[7:0] == 8'h00) ? 9 : (ir_q[7:4] == 4'd14) ? 10 : 8;
                8: ph <= 9;
                9: begin pc <= pc + 8'd1; ph <= 1; end
                default: ph <= 10;
            endcase
        end
    end

    // Compare every output on each falling edge
    always @(negedge clk) begin
        if (armed && !done) begin
            logic [20:0] exp_v, act_v;
            exp_v = expect_vec(ph, ir_q, flag_z, flag_c);
            act_v = {mem_rd, mem_wr, addr_from_reg, ir_load, pc_clr, pc_inc, pc_load,
                     rf_wr, rf_imm_sel, rf_left, rf_right, wp_clr, wp_add, alu_op,
                     flags_ld, flags_clr};
            n_tests++;
            if (act_v !== exp_v) begin
                n_fail++;
                $display("FAIL %s phase %0d ir %h: actual %h expected %h",
                         tag_of(ph, ir_q), ph, ir_q, act_v, exp_v);
            end
            n_tests++;  // R11: at most one PC action
            if ($countones({pc_clr, pc_inc, pc_load}) > 1) begin
                n_fail++;
                $display("FAIL R11 pc strobes actual %b expected at most one", {pc_clr, pc_inc, pc_load});
            end
        end
    end

    task automatic run_to_halt();
        bit seen = 1'b0;
        for (int i = 0; i < 600; i++) begin
            @(posedge clk);
            if (ph == 10) begin seen = 1'b1; break; end
        end
        n_tests++;
        if (!seen) begin
            n_fail++;
            $display("FAIL R9 halt reached actual 0 expected 1");
        end
        repeat (15) @(posedge clk);  // R9: outputs stay quiet in halt
    endtask

    task automatic finish_run();
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    endtask

    initial begin
        for (int i = 0; i < 64; i++) mem[i] = 16'h0000;
        mem[0]  = 16'h261C;  // add / mov (R3, R6)
        mem[1]  = 16'h9500;  // cmp, zero shadow (R5)
        mem[2]  = 16'hF85A;  // load immediate (R7)
        mem[3]  = 16'hB3C0;  // window step / flag clear
        mem[4]  = 16'hD605;  // store / opcode-0 shadow
        mem[5]  = 16'hF320;  // jump on carry (R8)
        mem[6]  = 16'hF208;  // jump on zero (R8)
        mem[7]  = 16'hE000;  // skipped
        mem[8]  = 16'hA74E;  // mul / and
        mem[9]  = 16'h6B87;  // not / shr
        mem[10] = 16'hF10C;  // unconditional jump
        mem[11] = 16'hE000;  // skipped
        mem[12] = 16'h55E0;  // or, then halt in lower byte (R9)
        mem[32] = 16'hE000;  // halt in upper byte (R9)

        // Run 1: zero set, carry clear -> jc falls through, jz taken
        flag_z = 1'b1; flag_c = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;
        run_to_halt();

        // Run 2: reset again (R1), carry set -> jc taken to word 32
        @(negedge clk) begin rst_n = 1'b0; flag_z = 1'b0; flag_c = 1'b1; end
        repeat (2) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;
        run_to_halt();

        @(negedge clk);
        finish_run();
    end

    initial begin
        #(5.0 * 20000);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog expired actual running expected finished");
        finish_run();
    end

endmodule